// File: doc/BRIEF.md
# Dual-Role SPI Controller with Multimaster Fault Detection

This block is one SPI port that can act as either the bus master or a slave. A control register selects the role. As master, it divides the system clock to make a gated serial clock, shifts a word out on MOSI and captures the reply from MISO. It also watches its own active-low select input, because another device pulling that line low means a second master is on the bus. As slave, it takes the clock and select from an external master, captures MOSI and returns its own word on MISO. A control bit can hold MISO released so that one master can broadcast to many slaves. Another bit turns MISO into an open-drain output.

Software reaches the block through a small four-word register interface. Address 0 is control. Address 1 is transmit data: a write starts a master transfer, or in slave mode it preloads the reply word. Address 2 is the received word. Address 3 is status. The slave path samples the external clock and select in the system clock domain, so the system clock must run at least four times faster than the serial clock.

Top module: `spi_dual_ctrl`

## Requirements
- R1: As master, `sck_o` rests at the clock polarity bit (control bit 2) whenever no word is moving. It toggles exactly twice per transferred bit and then returns to that level.
- R2: Each master serial-clock half period lasts DIV+1 system clock cycles. DIV is control bits [23:16]. The first edge comes DIV+1 cycles after the transmit write.
- R3: Words move MSB first. With clock phase 0 (control bit 3), bits are captured on the leading clock edge and the first bit is on the data line before that edge. With clock phase 1, bits are launched on the leading edge and captured on the trailing edge.
- R4: Control bits [9:8] set the word length: 0 selects 8 bits, 1 selects 16 bits, 2 or 3 select 32 bits. The received word at address 2 is right-aligned, with zeros above the word.
- R5: With master mode (control bit 1) and enable (control bit 0) set, a low level on `ss_ni` does four things. It sets sticky status bit 1, clears the enable bit, aborts the transfer (status bit 2 busy falls and `sck_o` returns to idle), and deasserts `sck_oe_o` and `mosi_oe_o`. Writing 1 to status bit 1 clears the flag.
- R6: As slave, edges on `sck_i` while `ss_ni` is high change neither the received word nor the done flag.
- R7: As slave with clock phase 0, the MSB of the transmit word is driven on MISO as soon as `ss_ni` falls, before any clock edge.
- R8: Pin direction follows the role. As enabled master, `sck_oe_o` and `mosi_oe_o` are 1 and `miso_oe_o` is 0. As slave, `sck_oe_o` and `mosi_oe_o` are 0, and MISO is driven only while `ss_ni` is low.
- R9: As slave, with the MISO-disable bit (control bit 5) set, `miso_oe_o` stays 0 for the whole transfer, and reception still completes.
- R10: With the open-drain bit (control bit 6) set, `miso_oe_o` is 1 only while the outgoing bit is 0, and `miso_o` is then 0. For a 1 bit the line is released.
- R11: Status bit 0 (done) is set once the last bit of a word has been captured. A transmit write that is accepted clears it, and so does writing 1 to status bit 0.
- R12: A transmit write while a master transfer is busy is ignored. The word on MOSI and the value read back from address 1 remain those of the running transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 control, 1 transmit, 2 receive, 3 status |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe_o | output | 1 | Serial clock output enable |
| sck_i | input | 1 | Serial clock in (slave) |
| ss_ni | input | 1 | Select in, active low: chip select as slave, fault sense as master |
| mosi_o | output | 1 | MOSI data out (master) |
| mosi_oe_o | output | 1 | MOSI output enable |
| mosi_i | input | 1 | MOSI data in (slave) |
| miso_o | output | 1 | MISO data out (slave) |
| miso_oe_o | output | 1 | MISO output enable |
| miso_i | input | 1 | MISO data in (master) |

## Verification
The bench sweeps every combination of polarity, phase and word length, in both roles and at two divisor values, and rebuilds each serial word bit by bit from the pins.

Swapped launch and capture edges corrupt the words in one phase. A slave that waits for a clock edge before presenting its first bit shifts its reply by one position. A wrong half-period count shows up as a wrong edge spacing, and a missing length mask leaves stale high bits in the received word.

Further targeted runs cover the remaining cases. A fault pulse in the middle of a transfer catches a master that keeps clocking or keeps its drivers on. Clock edges sent while the slave is deselected catch a slave that counts them. A write during a busy transfer catches one that reloads its shift register. The broadcast bit and the open-drain bit each get a run that checks the MISO enable at every sampled bit.

// File: rtl/spi_dual_pkg.sv
package spi_dual_pkg;
  localparam int unsigned DW   = 32;
  localparam int unsigned DIVW = 8;
  localparam int unsigned CNTW = $clog2(DW + 1);
  localparam int unsigned EW   = CNTW + 1;

  localparam int CTL_EN    = 0;
  localparam int CTL_MSTR  = 1;
  localparam int CTL_CPOL  = 2;
  localparam int CTL_CPHA  = 3;
  localparam int CTL_DMISO = 5;
  localparam int CTL_OPD   = 6;
  localparam int CTL_WL    = 8;
  localparam int CTL_DIV   = 16;
  localparam logic [DW-1:0] CTL_MASK = 32'h00FF_036F;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_TX   = 2'd1,
    A_RX   = 2'd2,
    A_STAT = 2'd3
  } reg_addr_e;

  function automatic logic [CNTW-1:0] word_bits(input logic [1:0] sel);
    case (sel)
      2'd0:    word_bits = CNTW'(8);
      2'd1:    word_bits = CNTW'(16);
      default: word_bits = CNTW'(32);
    endcase
  endfunction
endpackage

// File: rtl/spi_dual_sync.sv
module spi_dual_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic ss_ni,
  input  logic cpol_i,
  output logic ss_hi_o,
  output logic lead_o,
  output logic trail_o
);
  logic [STAGES-1:0] sck_ff, ss_ff;
  logic sck_d, sck_s, rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_ff <= '0;
      ss_ff  <= '1;
      sck_d  <= 1'b0;
    end else begin
      sck_ff <= {sck_ff[STAGES-2:0], sck_i};
      ss_ff  <= {ss_ff[STAGES-2:0], ss_ni};
      sck_d  <= sck_ff[STAGES-1];
    end
  end

  assign sck_s   = sck_ff[STAGES-1];
  assign ss_hi_o = ss_ff[STAGES-1];
  assign rise    = sck_s & ~sck_d;
  assign fall    = ~sck_s & sck_d;
  // deselected slave sees no edges at all
  assign lead_o  = ~ss_hi_o & (cpol_i ? fall : rise);
  assign trail_o = ~ss_hi_o & (cpol_i ? rise : fall);
endmodule

// File: rtl/spi_dual_tick.sv
module spi_dual_tick #(
  parameter int unsigned DIVW = 8,
  parameter int unsigned EW   = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            abort_i,
  input  logic [DIVW-1:0] div_i,
  input  logic [EW-1:0]   edges_i,
  input  logic            cpol_i,
  output logic            sck_o,
  output logic            lead_o,
  output logic            trail_o,
  output logic            busy_o
);
  logic            busy_q, ph_q, tick;
  logic [DIVW-1:0] div_q;
  logic [EW-1:0]   ecnt_q;

  assign tick = busy_q && (div_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      ph_q   <= 1'b0;
      div_q  <= '0;
      ecnt_q <= '0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
      ph_q   <= 1'b0;
      div_q  <= '0;
      ecnt_q <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      ph_q   <= 1'b0;
      div_q  <= '0;
      ecnt_q <= '0;
    end else if (tick) begin
      div_q  <= '0;
      ph_q   <= ~ph_q;
      ecnt_q <= ecnt_q + 1'b1;
      if (ecnt_q == edges_i - 1'b1) busy_q <= 1'b0;
    end else if (busy_q) begin
      div_q <= div_q + 1'b1;
    end
  end

  assign sck_o   = cpol_i ^ ph_q;
  assign lead_o  = tick & ~ecnt_q[0];
  assign trail_o = tick & ecnt_q[0];
  assign busy_o  = busy_q;

  p_idle_level_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !ph_q);
  p_half_period_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !tick && !abort_i) |=> $stable(ph_q));
endmodule

// File: rtl/spi_dual_shift.sv
module spi_dual_shift import spi_dual_pkg::*; (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] tx_i,
  input  logic [1:0]    wsel_i,
  input  logic          cpha_i,
  input  logic          lead_i,
  input  logic          trail_i,
  input  logic          din_i,
  output logic          dout_o,
  output logic          done_o,
  output logic [DW-1:0] rx_o
);
  logic [DW-1:0]   sh_q, rx_sh_q, rx_q, tx_al, rx_next;
  logic [CNTW-1:0] cnt_q, len;
  logic            done_q, cap, lau, active, last;

  assign len     = word_bits(wsel_i);
  assign active  = cnt_q < len;
  assign last    = cnt_q == len - 1'b1;
  assign cap     = active & (cpha_i ? trail_i : lead_i);
  // phase 1: the first leading edge presents the MSB that is already loaded
  assign lau     = active & (cpha_i ? (lead_i && cnt_q != '0) : trail_i);
  assign rx_next = {rx_sh_q[DW-2:0], din_i};

  always_comb begin
    case (wsel_i)
      2'd0:    tx_al = {tx_i[7:0], {(DW-8){1'b0}}};
      2'd1:    tx_al = {tx_i[15:0], {(DW-16){1'b0}}};
      default: tx_al = tx_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      rx_sh_q <= '0;
      rx_q    <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_i) begin
        sh_q    <= tx_al;
        rx_sh_q <= '0;
        cnt_q   <= '0;
      end else begin
        if (lau) sh_q <= {sh_q[DW-2:0], 1'b0};
        if (cap) begin
          rx_sh_q <= rx_next;
          cnt_q   <= cnt_q + 1'b1;
          if (last) begin
            rx_q   <= rx_next;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  assign dout_o = sh_q[DW-1];
  assign done_o = done_q;
  assign rx_o   = rx_q;
endmodule

// File: rtl/spi_dual_ctrl.sv
module spi_dual_ctrl import spi_dual_pkg::*; #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          sck_o,
  output logic          sck_oe_o,
  input  logic          sck_i,
  input  logic          ss_ni,
  output logic          mosi_o,
  output logic          mosi_oe_o,
  input  logic          mosi_i,
  output logic          miso_o,
  output logic          miso_oe_o,
  input  logic          miso_i
);
  logic [DW-1:0]   ctrl_q, tx_q, rx_word, sh_tx;
  logic            done_q, mm_err_q;
  logic            is_mstr, is_slv, ss_hi, s_lead, s_trail, m_lead, m_trail, m_sck, busy;
  logic            lead, trail, start, mm_hit, load, sh_done, sh_dout, miso_drv;
  logic            we_ctrl, we_tx, we_stat, tx_acc, clr_done;
  logic [1:0]      wsel;
  logic [CNTW-1:0] len;
  logic [DIVW-1:0] div;

  assign is_mstr  = ctrl_q[CTL_EN] & ctrl_q[CTL_MSTR];
  assign is_slv   = ctrl_q[CTL_EN] & ~ctrl_q[CTL_MSTR];
  assign wsel     = ctrl_q[CTL_WL +: 2];
  assign div      = ctrl_q[CTL_DIV +: DIVW];
  assign len      = word_bits(wsel);
  assign we_ctrl  = reg_we_i && (reg_addr_i == A_CTRL);
  assign we_tx    = reg_we_i && (reg_addr_i == A_TX);
  assign we_stat  = reg_we_i && (reg_addr_i == A_STAT);
  assign tx_acc   = we_tx && !busy;
  assign clr_done = tx_acc || (we_stat && reg_wdata_i[0]);
  assign start    = tx_acc && is_mstr;
  assign mm_hit   = is_mstr && !ss_hi;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      tx_q     <= '0;
      done_q   <= 1'b0;
      mm_err_q <= 1'b0;
    end else begin
      if (we_ctrl) ctrl_q <= reg_wdata_i & CTL_MASK;
      if (mm_hit) ctrl_q[CTL_EN] <= 1'b0;
      if (tx_acc) tx_q <= reg_wdata_i;
      if (sh_done) done_q <= 1'b1;
      else if (clr_done) done_q <= 1'b0;
      if (mm_hit) mm_err_q <= 1'b1;
      else if (we_stat && reg_wdata_i[1]) mm_err_q <= 1'b0;
    end
  end

  spi_dual_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .sck_i, .ss_ni,
    .cpol_i (ctrl_q[CTL_CPOL]),
    .ss_hi_o(ss_hi), .lead_o(s_lead), .trail_o(s_trail)
  );

  spi_dual_tick #(.DIVW(DIVW), .EW(EW)) u_tick (
    .clk_i, .rst_ni,
    .start_i(start), .abort_i(mm_hit), .div_i(div),
    .edges_i({len, 1'b0}), .cpol_i(ctrl_q[CTL_CPOL]),
    .sck_o(m_sck), .lead_o(m_lead), .trail_o(m_trail), .busy_o(busy)
  );

  assign lead  = is_mstr ? m_lead  : (is_slv & s_lead);
  assign trail = is_mstr ? m_trail : (is_slv & s_trail);
  assign load  = start | (is_slv & ss_hi);
  assign sh_tx = start ? reg_wdata_i : tx_q;

  spi_dual_shift u_shift (
    .clk_i, .rst_ni,
    .load_i(load), .tx_i(sh_tx), .wsel_i(wsel), .cpha_i(ctrl_q[CTL_CPHA]),
    .lead_i(lead), .trail_i(trail), .din_i(is_mstr ? miso_i : mosi_i),
    .dout_o(sh_dout), .done_o(sh_done), .rx_o(rx_word)
  );

  always_comb begin
    case (reg_addr_i)
      A_CTRL:  reg_rdata_o = ctrl_q;
      A_TX:    reg_rdata_o = tx_q;
      A_RX:    reg_rdata_o = rx_word;
      default: reg_rdata_o = {{(DW-3){1'b0}}, busy, mm_err_q, done_q};
    endcase
  end

  // raw select gates the driver so the first bit appears without sync delay
  assign miso_drv  = is_slv & ~ss_ni & ~ctrl_q[CTL_DMISO];
  assign sck_o     = m_sck;
  assign sck_oe_o  = is_mstr;
  assign mosi_o    = sh_dout;
  assign mosi_oe_o = is_mstr;
  assign miso_o    = ctrl_q[CTL_OPD] ? 1'b0 : sh_dout;
  assign miso_oe_o = miso_drv & (~ctrl_q[CTL_OPD] | ~sh_dout);

  p_mm_abort_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mm_hit |=> (mm_err_q && !ctrl_q[CTL_EN] && !sck_oe_o && !busy));
  p_one_driver_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mosi_oe_o && miso_oe_o));
  p_ss_ignore_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_slv && ss_hi && $past(ss_hi) && $past(is_slv)) |-> !sh_done);
  p_done_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !clr_done) |=> done_q);
  p_od_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q[CTL_OPD] && miso_oe_o) |-> !miso_o);
endmodule

// File: tb/spi_dual_ctrl_tb.sv
module spi_dual_ctrl_tb;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = 2'd0;
  logic [31:0] reg_wdata_i = '0, reg_rdata_o;
  logic        sck_o, sck_oe_o, sck_i = 1'b0, ss_ni = 1'b1;
  logic        mosi_o, mosi_oe_o, mosi_i = 1'b0;
  logic        miso_o, miso_oe_o, miso_i = 1'b0;
  int          n_chk = 0, n_err = 0;
  bit          fin = 1'b0;

  localparam int H = 6;

  always #2 clk_i = ~clk_i;

  spi_dual_ctrl u_dut (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 v = reg_rdata_o;
  endtask

  function automatic int blen(input int wsel);
    return (wsel == 0) ? 8 : (wsel == 1) ? 16 : 32;
  endfunction

  function automatic logic [31:0] bmask(input int len);
    return (len == 32) ? 32'hFFFF_FFFF : ((32'd1 << len) - 1);
  endfunction

  task automatic mxfer(input bit cpol, input bit cpha, input int wsel, input int div,
                       input logic [31:0] tx, input logic [31:0] sw, input bit poke);
    int len = blen(wsel);
    int nxt, edges = 0, cyc = 0, last = 0, guard = 0;
    bit prev, per_ok = 1'b1, oe_ok = 1'b1;
    logic [31:0] got = '0, v;
    wr(2'd0, 32'h3 | (32'(cpol) << 2) | (32'(cpha) << 3) | (32'(wsel) << 8) | (32'(div) << 16));
    #1 check(sck_o == cpol, "R1 idle level before", {31'b0, sck_o}, {31'b0, cpol});
    if (cpha == 1'b0) begin miso_i = sw[len-1]; nxt = len - 2; end
    else nxt = len - 1;
    wr(2'd1, tx);
    prev = cpol;
    while (edges < 2 * len && guard < 20000) begin
      @(negedge clk_i);
      guard++; cyc++;
      if (reg_we_i) reg_we_i = 1'b0;
      if (!(sck_oe_o && mosi_oe_o && !miso_oe_o)) oe_ok = 1'b0;
      if (sck_o != prev) begin
        edges++;
        prev = sck_o;
        if (cyc - last != div + 1) per_ok = 1'b0;
        last = cyc;
        if ((edges % 2 == 1) != cpha) got = {got[30:0], mosi_o};
        if ((edges % 2 == 1) == cpha && nxt >= 0) begin miso_i = sw[nxt]; nxt--; end
        if (poke && edges == 3) begin
          reg_we_i = 1'b1; reg_addr_i = 2'd1; reg_wdata_i = ~tx;
        end
      end
    end
    repeat (4) @(negedge clk_i);
    check(edges == 2 * len, "R1 edge count", edges, 2 * len);
    check(sck_o == cpol, "R1 idle level after", {31'b0, sck_o}, {31'b0, cpol});
    check(per_ok, "R2 half period", cyc, div + 1);
    check(oe_ok, "R8 master pin direction", {29'b0, sck_oe_o, mosi_oe_o, miso_oe_o}, 32'h6);
    check(got == (tx & bmask(len)), "R3 mosi word", got, tx & bmask(len));
    rd(2'd2, v);
    check(v == (sw & bmask(len)), "R4 rx word", v, sw & bmask(len));
    rd(2'd3, v);
    check(v == 32'h1, "R11 done set busy clear", v, 32'h1);
    if (poke) begin
      rd(2'd1, v);
      check(v == tx, "R12 tx write ignored while busy", v, tx);
    end
    wr(2'd3, 32'h1);
    rd(2'd3, v);
    check(v == 32'h0, "R11 done w1c", v, 32'h0);
  endtask

  task automatic sxfer(input bit cpol, input bit cpha, input int wsel, input bit dmiso,
                       input bit opd, input logic [31:0] tx, input logic [31:0] mw, input bit junk);
    int len = blen(wsel);
    bit eff, exp_b, bit_ok = 1'b1;
    logic [31:0] got = '0, v, rx0;
    wr(2'd0, 32'h1 | (32'(cpol) << 2) | (32'(cpha) << 3) | (32'(dmiso) << 5) |
             (32'(opd) << 6) | (32'(wsel) << 8));
    sck_i = cpol;
    wr(2'd1, tx);
    if (junk) begin
      rd(2'd2, rx0);
      for (int j = 0; j < 8; j++) begin
        repeat (H) @(negedge clk_i);
        sck_i = ~sck_i;
      end
      repeat (H) @(negedge clk_i);
      rd(2'd2, v);
      check(v == rx0, "R6 rx unchanged while deselected", v, rx0);
      rd(2'd3, v);
      check(v[0] == 1'b0, "R6 done unchanged while deselected", v, 32'h0);
    end
    repeat (H) @(negedge clk_i);
    if (!cpha) mosi_i = mw[len-1];
    ss_ni = 1'b0;
    #1;
    if (!cpha && !dmiso && !opd)
      check(miso_oe_o && miso_o == tx[len-1], "R7 first bit at select",
            {30'b0, miso_oe_o, miso_o}, {30'b0, 1'b1, tx[len-1]});
    check(!sck_oe_o && !mosi_oe_o, "R8 slave pin direction", {30'b0, sck_oe_o, mosi_oe_o}, 32'h0);
    for (int k = 1; k <= len; k++) begin
      repeat (H) @(negedge clk_i);
      exp_b = tx[len-k];
      if (!cpha) begin
        eff = miso_oe_o ? miso_o : 1'b1;
        got = {got[30:0], eff};
        if (dmiso && miso_oe_o) bit_ok = 1'b0;
        if (opd && (miso_oe_o != !exp_b || eff != exp_b)) bit_ok = 1'b0;
        if (!dmiso && !opd && !miso_oe_o) bit_ok = 1'b0;
      end else mosi_i = mw[len-k];
      sck_i = ~sck_i;
      repeat (H) @(negedge clk_i);
      if (cpha) begin
        eff = miso_oe_o ? miso_o : 1'b1;
        got = {got[30:0], eff};
        if (dmiso && miso_oe_o) bit_ok = 1'b0;
        if (opd && (miso_oe_o != !exp_b || eff != exp_b)) bit_ok = 1'b0;
        if (!dmiso && !opd && !miso_oe_o) bit_ok = 1'b0;
      end
      sck_i = ~sck_i;
      if (!cpha && k < len) mosi_i = mw[len-k-1];
    end
    repeat (H) @(negedge clk_i);
    ss_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    if (dmiso) check(bit_ok, "R9 miso held off", {31'b0, bit_ok}, 32'h1);
    else if (opd) check(bit_ok, "R10 open drain enable", {31'b0, bit_ok}, 32'h1);
    else check(bit_ok, "R8 slave drives miso", {31'b0, bit_ok}, 32'h1);
    if (!dmiso) check(got == (tx & bmask(len)), "R3 slave miso word", got, tx & bmask(len));
    rd(2'd2, v);
    check(v == (mw & bmask(len)), "R4 slave rx word", v, mw & bmask(len));
    rd(2'd3, v);
    check(v[0] == 1'b1, "R11 slave done", v, 32'h1);
    #1 check(miso_oe_o == 1'b0, "R8 released when deselected", {31'b0, miso_oe_o}, 32'h0);
  endtask

  task automatic mm_test();
    logic [31:0] v;
    wr(2'd0, 32'h0003_0203);
    wr(2'd1, 32'h1234_5678);
    repeat (20) @(negedge clk_i);
    ss_ni = 1'b0;
    repeat (5) @(negedge clk_i);
    rd(2'd3, v);
    check(v[2:1] == 2'b01, "R5 error set and busy cleared", v, 32'h2);
    rd(2'd0, v);
    check(v[0] == 1'b0, "R5 enable cleared", v, 32'h0003_0202);
    check(!sck_oe_o && !mosi_oe_o && sck_o == 1'b0, "R5 drivers off",
          {29'b0, sck_oe_o, mosi_oe_o, sck_o}, 32'h0);
    ss_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    rd(2'd3, v);
    check(v[1] == 1'b1, "R5 error sticky", v, 32'h2);
    wr(2'd3, 32'h2);
    rd(2'd3, v);
    check(v[1] == 1'b0, "R5 error w1c", v, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!fin) begin
      n_chk++; n_err++;
      $display("FAIL watchdog act=%0d exp=%0d", 200000, 0);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int idx = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    rd(2'd0, v);
    check(v == 32'h0, "R8 reset ctrl", v, 32'h0);
    rd(2'd3, v);
    check(v == 32'h0, "R11 reset status", v, 32'h0);
    check(!sck_oe_o && !mosi_oe_o && !miso_oe_o, "R8 reset enables",
          {29'b0, sck_oe_o, mosi_oe_o, miso_oe_o}, 32'h0);
    for (int p = 0; p < 2; p++)
      for (int h = 0; h < 2; h++)
        for (int w = 0; w < 3; w++)
          for (int d = 0; d < 3; d += 2) begin
            v = 32'hA5C3_0F96 ^ (32'(idx) * 32'h0123_4567);
            mxfer(p[0], h[0], w, d, v, {~v[15:0], v[31:16]}, idx == 5);
            idx++;
          end
    for (int p = 0; p < 2; p++)
      for (int h = 0; h < 2; h++)
        for (int w = 0; w < 3; w++) begin
          v = 32'h5E1D_C0B7 ^ (32'(idx) * 32'h0F0F_3355);
          sxfer(p[0], h[0], w, 1'b0, 1'b0, v, {v[7:0], ~v[31:8]}, w == 1);
          idx++;
        end
    sxfer(1'b0, 1'b0, 0, 1'b1, 1'b0, 32'h0000_00C3, 32'h0000_005A, 1'b0);
    sxfer(1'b1, 1'b1, 1, 1'b1, 1'b0, 32'h0000_9A3C, 32'h0000_6E21, 1'b0);
    sxfer(1'b0, 1'b0, 0, 1'b0, 1'b1, 32'h0000_00A6, 32'h0000_0039, 1'b0);
    sxfer(1'b0, 1'b1, 1, 1'b0, 1'b1, 32'h0000_C35A, 32'h0000_1E87, 1'b0);
    mm_test();
    fin = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule